// File: doc/BRIEF.md
# Folded Real-Input 16-Point DFT Engine

This block computes a 16-point discrete Fourier transform of one stored frame at a time. A start pulse opens a frame. Sixteen samples then arrive on a valid strobe and are kept in a small register file. The engine works through bins 0 to 8 with a single multiply-accumulate path. For each bin it forms two real sums: a cosine-weighted sum A and a sine-weighted sum B.

Before any multiply, the engine combines each sample with its mirror sample at index 16 − n. The cosine sum takes their sum and the sine sum takes their difference, so each bin needs nine terms instead of sixteen. Output indices 9 to 15 are never computed. They come from the symmetry of the transform, with one add or subtract applied to the same two sums.

A mode bit, captured at start, selects the inverse transform. In that mode the real and imaginary parts of an input spectrum feed the cosine and sine sums. The output pairs are then A − B and A + B.

Top module: `fold_dft16`

## Requirements
- R1: While reset is held and after it is released, `busy` and `resValid` are 0.
- R2: After a start pulse taken while idle, the next 16 cycles with `sampleValid` high load samples 0 to 15 in that order. Cycles with `sampleValid` low, samples offered while idle, and start pulses while busy have no effect on the results.
- R3: Weights are C(m) = round(256·cos(2πm/16)) and S(m) = round(256·sin(2πm/16)), with m = (k·n) mod 16. In forward mode, A(k) = Σ x(n)·C(m) and B(k) = Σ x(n)·S(m) over n = 0..15. Output index k, for k = 0..8, carries real part A(k)>>>4 and imaginary part (−B(k))>>>4, where >>> is an arithmetic shift.
- R4: In forward mode, output index 16 − k, for k = 1..7, carries real part A(k)>>>4 and imaginary part B(k)>>>4.
- R5: Indices 0 and 8 are emitted exactly once, and their imaginary part is 0.
- R6: In inverse mode, a(n) = `sampleRe` and b(n) = `sampleIm`, with A(k) = Σ a(n)·C(m) and B(k) = Σ b(n)·S(m). Output index k, for k = 0..8, carries A(k) − B(k), and index 16 − k, for k = 1..7, carries A(k) + B(k). Neither is scaled, and the imaginary part is 0.
- R7: Results leave in the index order 0, 1, 15, 2, 14, …, 7, 9, 8. Each pair k, 16 − k occupies consecutive cycles. When the samples follow the start back to back, the first result is valid 26 cycles after the start edge.
- R8: `busy` rises on the edge after an accepted start and stays high through the cycle that shows the last result. It is low in the cycle after that.
- R9: The mode is sampled only with an accepted start. Changing `invMode` during a frame does not affect that frame.
- R10: Each frame produces exactly 16 results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Opens a frame when idle |
| invMode | input | 1 | 1 selects the inverse transform |
| sampleValid | input | 1 | Qualifies the sample inputs |
| sampleRe | input | DW | Signed sample, or real part of a spectrum bin |
| sampleIm | input | DW | Signed imaginary part, used in inverse mode |
| busy | output | 1 | Frame in progress |
| resValid | output | 1 | Result valid |
| resIdx | output | 4 | Output bin or sample index |
| resRe | output | DW+CW+7 | Signed real part of the result |
| resIm | output | DW+CW+7 | Signed imaginary part of the result |

## Verification
A start edge followed by sixteen back-to-back samples puts the first result on the port 26 cycles later. That is sixteen load cycles, nine accumulate cycles and one output register. After that, each bin costs nine accumulate cycles plus one or two output cycles. The bench counts cycles from the start edge and compares each result with the index it expects in sequence. It also checks the first-result cycle on contiguous frames, and it checks that `busy` falls exactly one cycle after the result for index 8. The bench samples every output on the falling edge, and expected sums come from a direct 16-term sum with weights rounded from cos and sin.

// File: rtl/fold_dft_pkg.sv
package fold_dft_pkg;
  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int HALF  = N / 2;
  localparam int IDXW  = LOG2N;
  localparam int CW    = 10;   // weight width, unity = 256

  typedef struct packed {
    logic            load;
    logic [IDXW-1:0] loadIdx;
    logic            mac;
    logic [IDXW-1:0] termIdx;
    logic [IDXW-1:0] binIdx;
    logic            emitLo;
    logic            emitHi;
    logic            inv;
  } ctlStrobes_t;

  // first-quadrant magnitudes at multiples of 22.5 degrees
  function automatic logic signed [CW-1:0] quarterMag(input logic [2:0] step);
    case (step)
      3'd0:    quarterMag = CW'(256);
      3'd1:    quarterMag = CW'(237);
      3'd2:    quarterMag = CW'(181);
      3'd3:    quarterMag = CW'(98);
      default: quarterMag = '0;
    endcase
  endfunction

  // cos(2*pi*m/N) scaled by 256, folded from one quadrant
  function automatic logic signed [CW-1:0] coefAt(input logic [IDXW-1:0] m);
    logic [1:0] quad;
    logic [2:0] fine;
    logic [2:0] back;
    quad = m[IDXW-1:IDXW-2];
    fine = {1'b0, m[IDXW-3:0]};
    back = 3'd4 - fine;
    case (quad)
      2'd0:    coefAt = quarterMag(fine);
      2'd1:    coefAt = -quarterMag(back);
      2'd2:    coefAt = -quarterMag(fine);
      default: coefAt = quarterMag(back);
    endcase
  endfunction
endpackage

// File: rtl/fold_dft_ctrl.sv
module fold_dft_ctrl
  import fold_dft_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startPulse,
  input  logic        invMode,
  input  logic        sampleValid,
  output ctlStrobes_t ctl,
  output logic        engineActive
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_MAC, S_EMLO, S_EMHI} state_t;

  state_t          state;
  logic [IDXW-1:0] loadCnt;
  logic [IDXW-1:0] termCnt;
  logic [IDXW-1:0] binCnt;
  logic            invLatched;
  logic            binIsEdge;

  assign binIsEdge = (binCnt == '0) || (binCnt == IDXW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      loadCnt    <= '0;
      termCnt    <= '0;
      binCnt     <= '0;
      invLatched <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startPulse) begin
          state      <= S_LOAD;
          loadCnt    <= '0;
          invLatched <= invMode;
        end
        S_LOAD: if (sampleValid) begin
          loadCnt <= loadCnt + 1'b1;
          if (loadCnt == IDXW'(N - 1)) begin
            state   <= S_MAC;
            termCnt <= '0;
            binCnt  <= '0;
          end
        end
        S_MAC: begin
          termCnt <= termCnt + 1'b1;
          if (termCnt == IDXW'(HALF)) state <= S_EMLO;
        end
        S_EMLO: begin
          if (!binIsEdge) begin
            state <= S_EMHI;
          end else if (binCnt == IDXW'(HALF)) begin
            state <= S_IDLE;
          end else begin
            binCnt  <= binCnt + 1'b1;
            termCnt <= '0;
            state   <= S_MAC;
          end
        end
        default: begin
          binCnt  <= binCnt + 1'b1;
          termCnt <= '0;
          state   <= S_MAC;
        end
      endcase
    end
  end

  always_comb begin
    ctl.load    = (state == S_LOAD) && sampleValid;
    ctl.loadIdx = loadCnt;
    ctl.mac     = (state == S_MAC);
    ctl.termIdx = termCnt;
    ctl.binIdx  = binCnt;
    ctl.emitLo  = (state == S_EMLO);
    ctl.emitHi  = (state == S_EMHI);
    ctl.inv     = invLatched;
  end

  assign engineActive = (state != S_IDLE);
endmodule

// File: rtl/fold_dft_datapath.sv
module fold_dft_datapath
  import fold_dft_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctlStrobes_t               ctl,
  input  logic signed [DW-1:0]      sampleRe,
  input  logic signed [DW-1:0]      sampleIm,
  output logic                      resValid,
  output logic [IDXW-1:0]           resIdx,
  output logic signed [DW+CW+LOG2N+2:0] resRe,
  output logic signed [DW+CW+LOG2N+2:0] resIm
);
  localparam int FW = DW + 1;
  localparam int PW = FW + CW;
  localparam int AW = PW + LOG2N + 1;
  localparam int OW = AW + 1;

  logic signed [DW-1:0] memRe [N];
  logic signed [DW-1:0] memIm [N];

  for (genvar slot = 0; slot < N; slot++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctl.load && (ctl.loadIdx == IDXW'(slot))) begin
        memRe[slot] <= sampleRe;
        memIm[slot] <= sampleIm;
      end
    end
  end

  logic [IDXW-1:0]      termN, mirN, angle;
  logic                 edgeTerm;
  logic signed [DW-1:0] bNear, bFar;
  logic signed [FW-1:0] aFold, bFold;
  logic signed [CW-1:0] cosW, sinW;
  logic signed [PW-1:0] prodA, prodB;
  logic signed [AW-1:0] accA, accB;
  logic signed [OW-1:0] extA, extB;

  always_comb begin
    termN    = ctl.termIdx;
    mirN     = ~termN + 1'b1;
    edgeTerm = (termN == '0) || (termN == IDXW'(HALF));
    bNear    = ctl.inv ? memIm[termN] : memRe[termN];
    bFar     = ctl.inv ? memIm[mirN]  : memRe[mirN];
    if (edgeTerm) begin
      aFold = FW'(memRe[termN]);
      bFold = '0;
    end else begin
      aFold = FW'(memRe[termN]) + FW'(memRe[mirN]);
      bFold = FW'(bNear) - FW'(bFar);
    end
    angle = ctl.binIdx * termN;
    cosW  = coefAt(angle);
    sinW  = coefAt(angle - IDXW'(N / 4));
    prodA = PW'(aFold) * PW'(cosW);
    prodB = PW'(bFold) * PW'(sinW);
    extA  = OW'(accA);
    extB  = OW'(accB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accA <= '0;
      accB <= '0;
    end else if (ctl.mac) begin
      if (termN == '0) begin
        accA <= AW'(prodA);
        accB <= AW'(prodB);
      end else begin
        accA <= accA + AW'(prodA);
        accB <= accB + AW'(prodB);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resIdx   <= '0;
      resRe    <= '0;
      resIm    <= '0;
    end else begin
      resValid <= ctl.emitLo || ctl.emitHi;
      if (ctl.emitLo) begin
        resIdx <= ctl.binIdx;
        if (ctl.inv) begin
          resRe <= extA - extB;
          resIm <= '0;
        end else begin
          resRe <= extA >>> LOG2N;
          resIm <= (-extB) >>> LOG2N;
        end
      end else if (ctl.emitHi) begin
        resIdx <= ~ctl.binIdx + 1'b1;
        if (ctl.inv) begin
          resRe <= extA + extB;
          resIm <= '0;
        end else begin
          resRe <= extA >>> LOG2N;
          resIm <= extB >>> LOG2N;
        end
      end
    end
  end
endmodule

// File: rtl/fold_dft16.sv
module fold_dft16
  import fold_dft_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          startPulse,
  input  logic                          invMode,
  input  logic                          sampleValid,
  input  logic signed [DW-1:0]          sampleRe,
  input  logic signed [DW-1:0]          sampleIm,
  output logic                          busy,
  output logic                          resValid,
  output logic [IDXW-1:0]               resIdx,
  output logic signed [DW+CW+LOG2N+2:0] resRe,
  output logic signed [DW+CW+LOG2N+2:0] resIm
);
  ctlStrobes_t ctl;
  logic        engineActive;

  fold_dft_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .startPulse   (startPulse),
    .invMode      (invMode),
    .sampleValid  (sampleValid),
    .ctl          (ctl),
    .engineActive (engineActive)
  );

  fold_dft_datapath #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .sampleRe (sampleRe),
    .sampleIm (sampleIm),
    .resValid (resValid),
    .resIdx   (resIdx),
    .resRe    (resRe),
    .resIm    (resIm)
  );

  assign busy = engineActive || resValid;
endmodule

// File: rtl/fold_dft16_checker.sv
module fold_dft16_checker
  import fold_dft_pkg::*;
#(
  parameter int DW = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          startPulse,
  input logic                          invMode,
  input logic                          busy,
  input logic                          resValid,
  input logic [IDXW-1:0]               resIdx,
  input logic signed [DW+CW+LOG2N+2:0] resRe,
  input logic signed [DW+CW+LOG2N+2:0] resIm
);
  logic frameInv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frameInv <= 1'b0;
    else if (startPulse && !busy) frameInv <= invMode;
  end

  // R8: results only appear inside a busy window
  p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> busy);

  // R8: an accepted start raises busy on the next edge
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && !busy) |=> busy);

  // R5: the two self-mirrored bins are purely real
  p_edge_real_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && (resIdx == '0 || resIdx == IDXW'(HALF))) |-> (resIm == '0));

  // R6: inverse results carry no imaginary part
  p_inv_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && frameInv) |-> (resIm == '0));

  // R7: a lower bin 1..7 is followed at once by its mirror
  p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resIdx >= IDXW'(1) && resIdx <= IDXW'(HALF - 1))
      |=> (resValid && resIdx == IDXW'(N) - $past(resIdx)));

  // R4: an upper index never starts a burst
  p_upper_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resIdx > IDXW'(HALF)) |-> $past(resValid));

  logic unusedRe;
  assign unusedRe = ^resRe;
endmodule

bind fold_dft16 fold_dft16_checker #(.DW(DW)) u_chk (.*);

// File: tb/tb_fold_dft16.sv
`timescale 1ns/1ps
module tb_fold_dft16;
  localparam int DW = 12;
  localparam int OW = DW + 10 + 4 + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startPulse = 1'b0, invMode = 1'b0, sampleValid = 1'b0;
  logic signed [DW-1:0] sampleRe = '0, sampleIm = '0;
  logic busy, resValid;
  logic [3:0] resIdx;
  logic signed [OW-1:0] resRe, resIm;

  int checks = 0, fails = 0;
  longint cTab[16], sTab[16];
  longint inRe[16], inIm[16];
  longint expRe[16], expIm[16];
  int ord[16];
  int unsigned seed = 32'h1234_5678;
  int unsigned tick = 0;

  fold_dft16 #(.DW(DW)) dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tick > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL R8 watchdog: busy actual=%0b expected=0", busy);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic computeExpected(input bit inv);
    for (int k = 0; k <= 8; k++) begin
      longint a = 0, b = 0;
      for (int n = 0; n < 16; n++) begin
        a += inRe[n] * cTab[(k * n) % 16];
        b += (inv ? inIm[n] : inRe[n]) * sTab[(k * n) % 16];
      end
      if (inv) begin
        expRe[k] = a - b; expIm[k] = 0;
        if (k != 0 && k != 8) begin expRe[16 - k] = a + b; expIm[16 - k] = 0; end
      end else begin
        expRe[k] = a >>> 4; expIm[k] = (-b) >>> 4;
        if (k != 0 && k != 8) begin expRe[16 - k] = a >>> 4; expIm[16 - k] = b >>> 4; end
      end
    end
  endtask

  // gaps: insert idle-valid cycles; flip: toggle mode and pulse start mid-frame
  task automatic runFrame(input bit inv, input bit gaps, input bit flip, input string tag);
    int cyc, got, first, i;
    string req;
    computeExpected(inv);
    if (gaps) begin
      for (int g = 0; g < 3; g++) begin   // R2: samples while idle are ignored
        @(negedge clk);
        sampleValid = 1'b1; sampleRe = DW'(nextRand()); sampleIm = DW'(nextRand());
      end
    end
    @(negedge clk);
    sampleValid = 1'b0; invMode = inv; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; cyc = 0;
    check(busy === 1'b1, "R8", {tag, " busy after start"}, longint'(busy), 1);
    i = 0;
    while (i < 16) begin
      if (flip) begin invMode = ~inv; startPulse = (i == 5); end
      if (gaps && nextRand()[9]) begin
        sampleValid = 1'b0; sampleRe = DW'(nextRand()); sampleIm = DW'(nextRand());
      end else begin
        sampleValid = 1'b1; sampleRe = DW'(inRe[i]); sampleIm = DW'(inIm[i]); i++;
      end
      @(negedge clk); cyc++;
    end
    sampleValid = 1'b0; startPulse = 1'b0;
    got = 0; first = -1;
    while (got < 16 && cyc < 600) begin
      if (resValid) begin
        int idx = int'(resIdx);
        if (first < 0) first = cyc;
        check(idx == ord[got], "R7", {tag, " result order"}, idx, ord[got]);
        if (inv) req = "R6";
        else if (idx == 0 || idx == 8) req = "R5";
        else if (idx > 8) req = "R4";
        else req = "R3";
        check(longint'(resRe) == expRe[idx], req, $sformatf("%s real idx %0d", tag, idx),
              longint'(resRe), expRe[idx]);
        check(longint'(resIm) == expIm[idx], req, $sformatf("%s imag idx %0d", tag, idx),
              longint'(resIm), expIm[idx]);
        if (got == 15) check(busy === 1'b1, "R8", {tag, " busy on last result"}, longint'(busy), 1);
        got++;
      end
      @(negedge clk); cyc++;
    end
    check(busy === 1'b0 && resValid === 1'b0, "R8", {tag, " idle after last"},
          longint'({busy, resValid}), 0);
    check(got == 16, "R10", {tag, " result count"}, got, 16);
    if (!gaps) check(first == 26, "R7", {tag, " first result cycle"}, first, 26);
  endtask

  initial begin
    int p;
    for (int m = 0; m < 16; m++) begin
      cTab[m] = longint'(256.0 * $cos(2.0 * 3.14159265358979 * m / 16.0));
      sTab[m] = longint'(256.0 * $sin(2.0 * 3.14159265358979 * m / 16.0));
    end
    ord[0] = 0; p = 1;
    for (int k = 1; k < 8; k++) begin ord[p] = k; ord[p + 1] = 16 - k; p += 2; end
    ord[15] = 8;

    repeat (3) @(negedge clk);
    check(busy === 1'b0 && resValid === 1'b0, "R1", "outputs in reset", longint'({busy, resValid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && resValid === 1'b0, "R1", "outputs after reset", longint'({busy, resValid}), 0);

    for (int n = 0; n < 16; n++) begin inRe[n] = (n == 0) ? 1000 : 0; inIm[n] = 0; end
    runFrame(1'b0, 1'b0, 1'b0, "R3 impulse0");
    for (int n = 0; n < 16; n++) begin inRe[n] = (n == 3) ? -1500 : 0; inIm[n] = 0; end
    runFrame(1'b0, 1'b0, 1'b0, "R4 impulse3");
    for (int n = 0; n < 16; n++) begin inRe[n] = 2047; inIm[n] = 0; end
    runFrame(1'b0, 1'b0, 1'b0, "R5 dc-max");
    for (int n = 0; n < 16; n++) begin inRe[n] = n[0] ? -2048 : 2047; inIm[n] = 0; end
    runFrame(1'b0, 1'b0, 1'b0, "R5 nyquist");
    for (int n = 0; n < 16; n++) begin inRe[n] = -2048; inIm[n] = 0; end
    runFrame(1'b0, 1'b0, 1'b0, "R3 dc-min");
    for (int f = 0; f < 6; f++) begin
      for (int n = 0; n < 16; n++) begin
        inRe[n] = longint'($signed(DW'(nextRand() >> 7))); inIm[n] = 0;
      end
      runFrame(1'b0, f[0], f[1], f[0] ? "R2 fwd-gaps" : (f[1] ? "R9 fwd-flip" : "R3 fwd-rand"));
    end
    for (int f = 0; f < 6; f++) begin
      for (int n = 0; n < 16; n++) begin
        inRe[n] = longint'($signed(DW'(nextRand() >> 5)));
        inIm[n] = longint'($signed(DW'(nextRand() >> 9)));
      end
      runFrame(1'b1, f[0], f[1], f[0] ? "R2 inv-gaps" : (f[1] ? "R9 inv-flip" : "R6 inv-rand"));
    end
    for (int n = 0; n < 16; n++) begin inRe[n] = (n == 2) ? 2047 : 0; inIm[n] = (n == 5) ? -2048 : 0; end
    runFrame(1'b1, 1'b0, 1'b0, "R6 inv-impulse");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule